// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block produces the serial clock for an SPI master. It divides the system clock by the product of two programmable factors. A 2-bit prescale code selects a small factor of 2, 3, 5 or 7. A 4-bit scale code selects a factor that steps 2, 4, 6, 8 and then doubles up to 32768. Alongside the clock level it emits two one-cycle strobes that mark the leading edge and the trailing edge of each SCK period. The neighbouring shift engine uses these strobes to launch and capture data.

Software computes the codes and presents them with a polarity bit and a `run` level. A frame starts on the first clock edge at which `run` is seen high. At that edge the codes and the polarity are captured, and they hold for the whole frame. Inside each period, SCK first stays at its idle level for half the period and then stays at the active level for the other half. Because every scale factor is even, every product is even and the two halves are always equal. Dropping `run` returns SCK to idle on the next edge.

Top module: `sck_baud_gen`

## Requirements
- R1: Prescale code 0, 1, 2, 3 selects a factor of 2, 3, 5, 7 respectively.
- R2: Scale code c selects a factor of 2·(c+1) for c < 4 and of 2^c for c ≥ 4 (2 up to 32768).
- R3: With P = prescale × scale and the frame starting on edge 0, after edge k the strobe `lead_pulse` is high exactly when k mod P = P/2. The strobe `trail_pulse` is high exactly when k > 0 and k mod P = 0. SCK is at the active level exactly when k mod P ≥ P/2.
- R4: When `run` is low at an edge, from the next cycle SCK equals `cpol` and both strobes are low.
- R5: The idle level of SCK is `cpol` and the active level is its inverse. The polarity used in a frame is the value sampled at the frame's first edge.
- R6: Codes and polarity changed while a frame runs have no effect until the next frame.
- R7: Each strobe is one system-clock cycle wide, and the two strobes are never high together.
- R8: The smallest product, 4 (both codes 0), gives phases of 2 cycles each.
- R9: While `rst_n` is low (synchronous), SCK follows `cpol` and both strobes are low.
- R10: When `run` drops while SCK is at the active level, SCK returns to idle on the next edge with no trailing strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Frame enable level; a frame starts at the edge where it is first seen high |
| pre_code | input | 2 | Prescale code (factor 2/3/5/7) |
| scl_code | input | 4 | Scale code (factor 2..32768) |
| cpol | input | 1 | Idle level of SCK |
| sck | output | 1 | Serial clock level |
| lead_pulse | output | 1 | One-cycle strobe in the cycle SCK first shows its active level |
| trail_pulse | output | 1 | One-cycle strobe in the cycle SCK returns to idle at the end of a period |

## Verification
All three outputs are registered. A value sampled at edge k therefore shows up in the cycle after edge k. A leading strobe is due P/2 edges after the start edge and a trailing strobe P edges after it. The idle response to a low `run` is due one edge later. Inputs are driven on the falling clock edge and outputs are read on the falling edge, so each sample follows exactly one rising edge. The bench tracks the edge index k from the start edge and compares all three outputs against k mod P on every cycle of a frame.

// File: rtl/sck_baud_pkg.sv
// Package: shared widths and the factor decoding for the SCK prescaler.
// Assumes the scale code is at most 4 bits wide so that factors fit 32 bits.
package sck_baud_pkg;

    localparam int unsigned PRE_W = 2;
    localparam int unsigned SCL_W = 4;

    // Prescale factor: 2, 3, 5 or 7.
    function automatic int unsigned pre_factor(input logic [PRE_W-1:0] code);
        case (code)
            2'd0:    return 2;
            2'd1:    return 3;
            2'd2:    return 5;
            default: return 7;
        endcase
    endfunction

    // Scale factor: linear steps of 2 below code 4, powers of two from there.
    function automatic int unsigned scl_factor(input int unsigned code);
        if (code < 4)
            return 2 * (code + 1);
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/sck_baud_factor.sv
// Module: turns the captured codes into the period length and half period.
// Purely combinational; assumes the codes are held stable by the caller.
module sck_baud_factor
    import sck_baud_pkg::*;
#(
    parameter int unsigned CNT_W = 18
) (
    input  logic [PRE_W-1:0] pre_q,
    input  logic [SCL_W-1:0] scl_q,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] half
);

    // Period is the product of the two factors; half splits it evenly.
    always_comb begin
        period = CNT_W'(pre_factor(pre_q) * scl_factor(32'(scl_q)));
        half   = period >> 1;
    end

endmodule

// File: rtl/sck_phase_ctr.sv
// Module: counts system-clock cycles modulo the SCK period.
// Assumes period >= 4 and that period only changes while clear is high.
module sck_phase_ctr #(
    parameter int unsigned CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);

    // Next count: wrap to zero after the last cycle of a period.
    always_comb begin
        if (cnt == period - CNT_W'(1))
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + CNT_W'(1);
    end

    // Count register: cleared while idle, advances during a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    // R3: the position in the period never leaves the period.
    assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> cnt < period);

endmodule

// File: rtl/sck_baud_gen.sv
// Module: SPI serial-clock generator with prescale x scale division.
// Captures codes and polarity at frame start; outputs are registered.
// Assumes run is synchronous to clk.
module sck_baud_gen
    import sck_baud_pkg::*;
#(
    parameter int unsigned P_W = PRE_W,
    parameter int unsigned S_W = SCL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [P_W-1:0] pre_code,
    input  logic [S_W-1:0] scl_code,
    input  logic           cpol,
    output logic           sck,
    output logic           lead_pulse,
    output logic           trail_pulse
);

    localparam longint unsigned PROD_MAX = 64'd7 * (64'd1 << ((1 << S_W) - 1));
    localparam int unsigned     CNT_W    = $clog2(PROD_MAX + 1);

    logic             active;
    logic             cpol_q;
    logic [P_W-1:0]   pre_q;
    logic [S_W-1:0]   scl_q;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    sck_baud_factor #(.CNT_W(CNT_W)) u_factor (
        .pre_q  (pre_q),
        .scl_q  (scl_q),
        .period (period),
        .half   (half)
    );

    sck_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!run || !active),
        .period  (period),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt)
    );

    // Frame control: capture settings at start, hold them while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cpol_q <= 1'b0;
            pre_q  <= '0;
            scl_q  <= '0;
        end else if (!run) begin
            active <= 1'b0;
        end else if (!active) begin
            active <= 1'b1;
            cpol_q <= cpol;
            pre_q  <= pre_code;
            scl_q  <= scl_code;
        end
    end

    // Output stage: SCK level and edge strobes from the next count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !active) begin
            sck         <= cpol;
            lead_pulse  <= 1'b0;
            trail_pulse <= 1'b0;
        end else begin
            sck         <= cpol_q ^ (cnt_nxt >= half);
            lead_pulse  <= (cnt_nxt == half);
            trail_pulse <= (cnt_nxt == '0);
        end
    end

    // R4: a low run leaves SCK idle with no strobes on the next cycle.
    assert_idle_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sck == $past(cpol)) && !lead_pulse && !trail_pulse);

    // R7: strobes never coincide.
    assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_pulse && trail_pulse));

    // R7: each strobe lasts a single cycle.
    assert_lead_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lead_pulse |=> !lead_pulse);
    assert_trail_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_pulse |=> !trail_pulse);

    // R5: a leading strobe coincides with SCK at the active level.
    assert_lead_active_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lead_pulse |-> sck != cpol_q);

    // R6: captured settings do not move inside a running frame.
    assert_codes_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && $past(run)) |-> $stable(pre_q) && $stable(scl_q) && $stable(cpol_q));

endmodule

// File: tb/tb_sck_baud_gen.sv
module tb_sck_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [1:0] pre_code = '0;
    logic [3:0] scl_code = '0;
    logic       cpol = 1'b0;
    logic       sck, lead_pulse, trail_pulse;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk; // 50 MHz

    sck_baud_gen dut (
        .clk(clk), .rst_n(rst_n), .run(run), .pre_code(pre_code),
        .scl_code(scl_code), .cpol(cpol), .sck(sck),
        .lead_pulse(lead_pulse), .trail_pulse(trail_pulse)
    );

    function automatic int pre_val(input logic [1:0] c);
        int t[4] = '{2, 3, 5, 7};
        return t[c];
    endfunction

    function automatic int scl_val(input logic [3:0] c);
        int v = 2;
        for (int i = 1; i <= int'(c); i++) v = (i < 4) ? v + 2 : v * 2;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One frame of the given number of periods; optional code change at cycle chg_at.
    task automatic run_frame(input logic [1:0] pc, input logic [3:0] sc, input logic cp,
                             input int periods, input int chg_at, input string req);
        int p, h, m, bad, act_v, exp_v;
        logic es, el, et;
        p = pre_val(pc) * scl_val(sc);
        h = p / 2;
        bad = 0; act_v = 0; exp_v = 0;
        @(negedge clk);
        pre_code = pc; scl_code = sc; cpol = cp; run = 1'b1;
        for (int k = 0; k <= periods * p; k++) begin
            @(negedge clk);
            m  = k % p;
            es = cp ^ (m >= h);
            el = (m == h);
            et = (m == 0) && (k > 0);
            if ({sck, lead_pulse, trail_pulse} !== {es, el, et}) begin
                if (bad == 0) begin
                    act_v = {sck, lead_pulse, trail_pulse};
                    exp_v = {es, el, et};
                end
                bad++;
            end
            if (k == chg_at) begin
                pre_code = ~pc; scl_code = sc ^ 4'h1; cpol = ~cp;
            end
        end
        check(bad == 0, req, act_v, exp_v);
        run = 1'b0;
        @(negedge clk);
        check(sck == cpol && !lead_pulse && !trail_pulse, "R4 idle after stop",
              {sck, lead_pulse, trail_pulse}, {cpol, 2'b00});
    endtask

    task automatic test_reset();
        rst_n = 1'b0; run = 1'b1; cpol = 1'b1;
        repeat (3) @(negedge clk);
        check(sck == 1'b1 && !lead_pulse && !trail_pulse, "R9 reset cpol=1",
              {sck, lead_pulse, trail_pulse}, 3'b100);
        cpol = 1'b0;
        @(negedge clk);
        check(sck == 1'b0 && !lead_pulse && !trail_pulse, "R9 reset cpol=0",
              {sck, lead_pulse, trail_pulse}, 3'b000);
        run = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_min_product();
        run_frame(2'd0, 4'd0, 1'b0, 3, -1, "R8 product 4 two-cycle phases");
    endtask

    task automatic test_prescalers();
        for (int c = 0; c < 4; c++)
            run_frame(2'(c), 4'd0, 1'b0, 2, -1, "R1 prescale factor");
    endtask

    task automatic test_scalers();
        for (int c = 0; c < 13; c++)
            run_frame(2'd0, 4'(c), 1'b0, 2, -1, "R2 scale factor");
        run_frame(2'd0, 4'd15, 1'b0, 1, -1, "R2 scale factor 32768");
        run_frame(2'd3, 4'd5, 1'b0, 2, -1, "R3 combined period 224");
    endtask

    task automatic test_polarity();
        run_frame(2'd1, 4'd1, 1'b1, 2, -1, "R5 idle high polarity");
        run_frame(2'd2, 4'd2, 1'b1, 2, -1, "R5 polarity with prescale 5");
    endtask

    task automatic test_code_change();
        run_frame(2'd1, 4'd2, 1'b0, 3, 5, "R6 mid-frame change ignored");
        run_frame(2'd2, 4'd0, 1'b1, 2, 0, "R6 change after start edge ignored");
    endtask

    task automatic test_stop_mid();
        @(negedge clk);
        pre_code = 2'd0; scl_code = 4'd1; cpol = 1'b0; run = 1'b1; // P = 8, h = 4
        for (int k = 0; k <= 5; k++) @(negedge clk);
        check(sck == 1'b1, "R10 active before stop", sck, 1);
        run = 1'b0;
        @(negedge clk);
        check(sck == 1'b0 && !trail_pulse && !lead_pulse, "R10 stop without trailing strobe",
              {sck, lead_pulse, trail_pulse}, 3'b000);
        repeat (10) @(negedge clk);
        check(sck == 1'b0 && !trail_pulse && !lead_pulse, "R4 stays idle",
              {sck, lead_pulse, trail_pulse}, 3'b000);
        run_frame(2'd0, 4'd0, 1'b0, 2, -1, "R7 restart strobes single-cycle");
    endtask

    initial begin
        test_reset();
        test_min_product();
        test_prescalers();
        test_scalers();
        test_polarity();
        test_code_change();
        test_stop_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule